// File: doc/BRIEF.md
# Programmable-Format Serial Character Receiver

This block turns an asynchronous serial line into characters. The line is first passed through a two-flop synchronizer. A 16-bit divisor sets a sampling tick that runs sixteen times faster than the bit rate. A state machine checks each start bit, samples every bit at its centre and checks the character's trailer. A control byte sets the word length, the parity handling and the stop-bit setting while the block runs.

Each finished character goes into a one-entry holding register and sets a ready flag. The host reads the character with a data read strobe. It reads and clears the error flags with a separate status strobe. The error flags are overrun, parity, framing and break.

The state machine has six states:
- IDLE waits for the line to go low on a tick, then goes to START.
- START confirms the start bit at its midpoint. It goes to DATA if the line is still low, or back to IDLE on a false start.
- DATA collects the programmed number of bits. It then goes to PARITY if parity is on, or to STOP otherwise.
- PARITY samples one bit and goes to STOP.
- STOP samples the first stop bit and finishes the character. It goes to HOLD if the whole frame was low (a break), or to IDLE otherwise.
- HOLD waits for the line to go high again, then goes to IDLE.

Top module: `serial_rx_core`

## Requirements
- R1: The sampling tick fires once every `divisor` clocks, so one bit lasts 16×divisor clocks. A divisor of 0 behaves as 1.
- R2: A low level seen on a tick in IDLE is confirmed 8 ticks later. If the line is high at that point, the receiver returns to IDLE and delivers no character.
- R3: `line_ctrl[1:0]` sets the word length: 00=5, 01=6, 10=7, 11=8 bits. Bits arrive LSB first, land in the low bits of `rx_data`, and the unused upper bits read 0.
- R4: `line_ctrl[3]`=1 enables a parity bit after the data. With `line_ctrl[5]`=0, `line_ctrl[4]`=1 selects even parity and 0 selects odd parity, counted over the data plus the parity bit. A mismatch sets `parity_err`.
- R5: With `line_ctrl[3]`=1 and `line_ctrl[5]`=1, the parity bit must be 0 when `line_ctrl[4]`=1 and 1 when `line_ctrl[4]`=0. Any other value sets `parity_err`.
- R6: Only the first stop bit is sampled, whatever the value of `line_ctrl[2]`. If it is low and the frame was not all zeros, `framing_err` is set and the data is still delivered.
- R7: A frame whose data, parity and first stop bit are all low sets `break_det` and not `framing_err`. It delivers 0x00, and no new start is seen until the line returns high.
- R8: A finished character loads `rx_data` and sets `data_ready`. A `rd_data` pulse clears `data_ready`, unless a character finishes in that same cycle.
- R9: If a character finishes while `data_ready` is set and no read is happening, the new character replaces the old one and `overrun_err` is set.
- R10: A `rd_status` pulse clears `overrun_err`, `parity_err`, `framing_err` and `break_det`. A flag set in the same cycle wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| divisor | input | 16 | Clocks per sampling tick |
| line_ctrl | input | 8 | Format control: [1:0] length, [2] stop setting, [3] parity on, [4] parity select, [5] sticky |
| rx_in | input | 1 | Asynchronous serial line, idle high |
| rd_data | input | 1 | One-cycle read of the holding register |
| rd_status | input | 1 | One-cycle read of the error flags |
| rx_data | output | 8 | Holding register |
| data_ready | output | 1 | A character is waiting |
| overrun_err | output | 1 | An unread character was overwritten |
| parity_err | output | 1 | Parity mismatch |
| framing_err | output | 1 | First stop bit was low |
| break_det | output | 1 | Whole frame held low |

## Verification
The bench builds the block with its default parameters: 16-bit divisor, 16× oversampling and 8-bit data. It drives the divisor port at run time with the values 4, 1, 0 and 7. Small divisors keep each character within about a thousand clocks. This lets one short run cover every word length, every parity mode, framing, break, false start and overrun. Odd and degenerate divisors check that the bit centres stay correct when the tick fires on every clock or at irregular spacing.

// File: rtl/srx_pkg.sv
package srx_pkg;
    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_PARITY,
        RX_STOP,
        RX_HOLD
    } rx_state_t;

    localparam int LC_PAR_ON  = 3;
    localparam int LC_PAR_SEL = 4;
    localparam int LC_STICKY  = 5;
endpackage

// File: rtl/srx_sync.sv
module srx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] stage_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q <= '1;
        else        stage_q <= {stage_q[STAGES-2:0], din};
    end

    assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/srx_tick_gen.sv
module srx_tick_gen #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] divisor,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_q;
    logic [DIV_W-1:0] last_cnt;

    always_comb begin
        last_cnt = (divisor == '0) ? '0 : divisor - DIV_W'(1);
        tick     = (cnt_q >= last_cnt);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    cnt_q <= '0;
        else if (tick) cnt_q <= '0;
        else           cnt_q <= cnt_q + DIV_W'(1);
    end
endmodule

// File: rtl/srx_frame_fsm.sv
module srx_frame_fsm
    import srx_pkg::*;
#(
    parameter int OSR    = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              rx_s,
    input  logic [7:0]        line_ctrl,
    output logic              done,
    output logic [DATA_W-1:0] data,
    output logic              perr,
    output logic              ferr,
    output logic              brk
);
    localparam int CNT_W = $clog2(OSR);
    localparam int IDX_W = $clog2(DATA_W);
    localparam logic [CNT_W-1:0] MID_LAST = CNT_W'(OSR/2 - 1);
    localparam logic [CNT_W-1:0] BIT_LAST = CNT_W'(OSR - 1);

    rx_state_t         state_q, state_d;
    logic [CNT_W-1:0]  cnt_q;
    logic [IDX_W-1:0]  idx_q;
    logic [DATA_W-1:0] shreg_q;
    logic              par_q;

    logic              par_on, bit_end, all_zero, exp_par;
    logic [IDX_W-1:0]  last_idx;
    logic              lc_unused;

    assign lc_unused = ^{line_ctrl[7:6], line_ctrl[2]};

    always_comb begin
        par_on   = line_ctrl[LC_PAR_ON];
        last_idx = {1'b1, line_ctrl[1:0]};
        bit_end  = tick && (cnt_q == BIT_LAST);
        all_zero = (shreg_q == '0) && !par_q;
        if (line_ctrl[LC_STICKY]) exp_par = ~line_ctrl[LC_PAR_SEL];
        else if (line_ctrl[LC_PAR_SEL]) exp_par = ^shreg_q;
        else exp_par = ~(^shreg_q);
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RX_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RX_IDLE:   if (tick && !rx_s) state_d = RX_START;
            RX_START:  if (tick && cnt_q == MID_LAST) state_d = rx_s ? RX_IDLE : RX_DATA;
            RX_DATA:   if (bit_end && idx_q == last_idx) state_d = par_on ? RX_PARITY : RX_STOP;
            RX_PARITY: if (bit_end) state_d = RX_STOP;
            RX_STOP:   if (bit_end) state_d = (!rx_s && all_zero) ? RX_HOLD : RX_IDLE;
            RX_HOLD:   if (rx_s) state_d = RX_IDLE;
            default:   state_d = RX_IDLE;
        endcase
    end

    // bit timing and shift datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            idx_q   <= '0;
            shreg_q <= '0;
            par_q   <= 1'b0;
        end else if (tick) begin
            unique case (state_q)
                RX_IDLE: begin
                    cnt_q <= '0;
                    idx_q <= '0;
                    if (!rx_s) begin
                        shreg_q <= '0;
                        par_q   <= 1'b0;
                    end
                end
                RX_START: cnt_q <= (cnt_q == MID_LAST) ? '0 : cnt_q + CNT_W'(1);
                RX_DATA: begin
                    cnt_q <= cnt_q + CNT_W'(1);
                    if (cnt_q == BIT_LAST) begin
                        shreg_q[idx_q] <= rx_s;
                        idx_q          <= idx_q + IDX_W'(1);
                    end
                end
                RX_PARITY: begin
                    cnt_q <= cnt_q + CNT_W'(1);
                    if (cnt_q == BIT_LAST) par_q <= rx_s;
                end
                RX_STOP: cnt_q <= cnt_q + CNT_W'(1);
                RX_HOLD: cnt_q <= '0;
                default: cnt_q <= '0;
            endcase
        end
    end

    // outputs
    always_comb begin
        done = (state_q == RX_STOP) && bit_end;
        brk  = done && !rx_s && all_zero;
        ferr = done && !rx_s && !all_zero;
        perr = done && !brk && par_on && (par_q != exp_par);
        data = shreg_q;
    end
endmodule

// File: rtl/srx_status.sv
module srx_status #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              done,
    input  logic [DATA_W-1:0] new_data,
    input  logic              new_perr,
    input  logic              new_ferr,
    input  logic              new_brk,
    input  logic              rd_data,
    input  logic              rd_status,
    output logic [DATA_W-1:0] rx_data,
    output logic              data_ready,
    output logic              overrun_err,
    output logic              parity_err,
    output logic              framing_err,
    output logic              break_det
);
    logic lost;

    assign lost = done && data_ready && !rd_data;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_data     <= '0;
            data_ready  <= 1'b0;
            overrun_err <= 1'b0;
            parity_err  <= 1'b0;
            framing_err <= 1'b0;
            break_det   <= 1'b0;
        end else begin
            if (done) rx_data <= new_data;
            data_ready  <= done | (data_ready & ~rd_data);
            overrun_err <= lost | (overrun_err & ~rd_status);
            parity_err  <= new_perr | (parity_err & ~rd_status);
            framing_err <= new_ferr | (framing_err & ~rd_status);
            break_det   <= new_brk | (break_det & ~rd_status);
        end
    end
endmodule

// File: rtl/serial_rx_core.sv
module serial_rx_core #(
    parameter int DIV_W  = 16,
    parameter int OSR    = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DIV_W-1:0]  divisor,
    input  logic [7:0]        line_ctrl,
    input  logic              rx_in,
    input  logic              rd_data,
    input  logic              rd_status,
    output logic [DATA_W-1:0] rx_data,
    output logic              data_ready,
    output logic              overrun_err,
    output logic              parity_err,
    output logic              framing_err,
    output logic              break_det
);
    logic              rx_s;
    logic              tick_w;
    logic              done_w;
    logic [DATA_W-1:0] data_w;
    logic              perr_w, ferr_w, brk_w;

    srx_sync #(.STAGES(2)) u_sync (
        .clk(clk), .rst_n(rst_n), .din(rx_in), .dout(rx_s)
    );

    srx_tick_gen #(.DIV_W(DIV_W)) u_tick (
        .clk(clk), .rst_n(rst_n), .divisor(divisor), .tick(tick_w)
    );

    srx_frame_fsm #(.OSR(OSR), .DATA_W(DATA_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .tick(tick_w), .rx_s(rx_s),
        .line_ctrl(line_ctrl), .done(done_w), .data(data_w),
        .perr(perr_w), .ferr(ferr_w), .brk(brk_w)
    );

    srx_status #(.DATA_W(DATA_W)) u_status (
        .clk(clk), .rst_n(rst_n), .done(done_w), .new_data(data_w),
        .new_perr(perr_w), .new_ferr(ferr_w), .new_brk(brk_w),
        .rd_data(rd_data), .rd_status(rd_status),
        .rx_data(rx_data), .data_ready(data_ready),
        .overrun_err(overrun_err), .parity_err(parity_err),
        .framing_err(framing_err), .break_det(break_det)
    );
endmodule

// File: rtl/serial_rx_core_chk.sv
module serial_rx_core_chk #(
    parameter int DIV_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic [DIV_W-1:0] divisor,
    input logic             tick,
    input logic             char_done,
    input logic             rd_data,
    input logic             rd_status,
    input logic             data_ready,
    input logic             overrun_err,
    input logic             parity_err,
    input logic             framing_err,
    input logic             break_det
);
    a_r1_fast_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (divisor <= DIV_W'(1)) |-> tick);

    a_r8_ready_on_done: assert property (@(posedge clk) disable iff (!rst_n)
        char_done |=> data_ready);

    a_r8_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data && !char_done) |=> !data_ready);

    a_r9_overrun_set: assert property (@(posedge clk) disable iff (!rst_n)
        (char_done && data_ready && !rd_data) |=> overrun_err);

    a_r10_status_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_status && !char_done) |=> !(overrun_err || parity_err || framing_err || break_det));

    a_r7_break_not_framing: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(break_det) |-> !$rose(framing_err));
endmodule

bind serial_rx_core serial_rx_core_chk #(.DIV_W(DIV_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .divisor(divisor), .tick(tick_w),
    .char_done(done_w), .rd_data(rd_data), .rd_status(rd_status),
    .data_ready(data_ready), .overrun_err(overrun_err),
    .parity_err(parity_err), .framing_err(framing_err), .break_det(break_det)
);

// File: tb/serial_rx_core_tb_top.sv
`timescale 1ns/1ps
module serial_rx_core_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] divisor = 16'd4;
    logic [7:0]  line_ctrl = 8'h03;
    logic        rx_in = 1'b1;
    logic        rd_data = 1'b0;
    logic        rd_status = 1'b0;
    logic [7:0]  rx_data;
    logic        data_ready, overrun_err, parity_err, framing_err, break_det;

    int total = 0;
    int bad = 0;

    always #2.5 clk = ~clk;

    serial_rx_core dut_i (
        .clk(clk), .rst_n(rst_n), .divisor(divisor), .line_ctrl(line_ctrl),
        .rx_in(rx_in), .rd_data(rd_data), .rd_status(rd_status),
        .rx_data(rx_data), .data_ready(data_ready), .overrun_err(overrun_err),
        .parity_err(parity_err), .framing_err(framing_err), .break_det(break_det)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wclk(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    function automatic int bitlen();
        return 16 * ((divisor == 16'd0) ? 1 : int'(divisor));
    endfunction

    function automatic logic good_par(input logic [7:0] d, input int wl);
        logic [7:0] m;
        m = d & 8'((1 << wl) - 1);
        if (line_ctrl[5]) return ~line_ctrl[4];
        if (line_ctrl[4]) return ^m;
        return ~(^m);
    endfunction

    // one frame: start, wl data bits LSB first, optional parity, first stop, extra stops
    task automatic send(input logic [7:0] d, input bit flip_par, input logic stop_v, input int nstop);
        int wl;
        wl = 5 + int'(line_ctrl[1:0]);
        rx_in = 1'b0; wclk(bitlen());
        for (int i = 0; i < wl; i++) begin
            rx_in = d[i]; wclk(bitlen());
        end
        if (line_ctrl[3]) begin
            rx_in = good_par(d, wl) ^ flip_par; wclk(bitlen());
        end
        rx_in = stop_v; wclk(bitlen());
        rx_in = 1'b1;
        for (int i = 1; i < nstop; i++) wclk(bitlen());
        wclk(2 * bitlen());
    endtask

    task automatic read_both();
        @(posedge clk); #1; rd_data = 1'b1; rd_status = 1'b1;
        @(posedge clk); #1; rd_data = 1'b0; rd_status = 1'b0;
    endtask

    task automatic expect_char(input string tag, input logic [7:0] d, input logic pe, input logic fe);
        chk(data_ready === 1'b1, {tag, " ready"}, int'(data_ready), 1);
        chk(rx_data === d, {tag, " data"}, int'(rx_data), int'(d));
        chk(parity_err === pe, {tag, " parity"}, int'(parity_err), int'(pe));
        chk(framing_err === fe, {tag, " framing"}, int'(framing_err), int'(fe));
    endtask

    task automatic t_reset();
        chk(data_ready === 1'b0, "R8 reset ready", int'(data_ready), 0);
        chk({overrun_err, parity_err, framing_err, break_det} === 4'b0, "R10 reset flags",
            int'({overrun_err, parity_err, framing_err, break_det}), 0);
        chk(rx_data === 8'h00, "R8 reset data", int'(rx_data), 0);
    endtask

    task automatic t_basic();
        divisor = 16'd4; line_ctrl = 8'h03;
        send(8'hA5, 0, 1'b1, 1);
        expect_char("R1 R3 R8 basic", 8'hA5, 1'b0, 1'b0);
        @(posedge clk); #1; rd_data = 1'b1;
        @(posedge clk); #1; rd_data = 1'b0;
        chk(data_ready === 1'b0, "R8 read clears ready", int'(data_ready), 0);
        chk(rx_data === 8'hA5, "R8 data held after read", int'(rx_data), 8'hA5);
    endtask

    task automatic t_wordlen();
        for (int wl = 5; wl <= 8; wl++) begin
            line_ctrl = 8'(wl - 5);
            send(8'hB6, 0, 1'b1, 1);
            expect_char("R3 word length", 8'hB6 & 8'((1 << wl) - 1), 1'b0, 1'b0);
            read_both();
        end
    endtask

    task automatic t_parity();
        line_ctrl = 8'h1B; // 8 bits, parity on, even
        send(8'h37, 0, 1'b1, 1);
        expect_char("R4 even good", 8'h37, 1'b0, 1'b0);
        read_both();
        send(8'h37, 1, 1'b1, 1);
        expect_char("R4 even bad", 8'h37, 1'b1, 1'b0);
        read_both();
        chk(parity_err === 1'b0, "R10 status read clears parity", int'(parity_err), 0);
        line_ctrl = 8'h0A; // 7 bits, parity on, odd
        send(8'h55, 0, 1'b1, 1);
        expect_char("R4 odd good", 8'h55, 1'b0, 1'b0);
        read_both();
        send(8'h55, 1, 1'b1, 1);
        expect_char("R4 odd bad", 8'h55, 1'b1, 1'b0);
        read_both();
    endtask

    task automatic t_sticky();
        line_ctrl = 8'h2B; // sticky, select 0: parity bit must be 1
        send(8'h0F, 0, 1'b1, 1);
        expect_char("R5 sticky one good", 8'h0F, 1'b0, 1'b0);
        read_both();
        send(8'h0F, 1, 1'b1, 1);
        expect_char("R5 sticky one bad", 8'h0F, 1'b1, 1'b0);
        read_both();
        line_ctrl = 8'h3B; // sticky, select 1: parity bit must be 0
        send(8'h0E, 0, 1'b1, 1);
        expect_char("R5 sticky zero good", 8'h0E, 1'b0, 1'b0);
        read_both();
        send(8'h0E, 1, 1'b1, 1);
        expect_char("R5 sticky zero bad", 8'h0E, 1'b1, 1'b0);
        read_both();
    endtask

    task automatic t_framing();
        line_ctrl = 8'h03;
        send(8'h81, 0, 1'b0, 1);
        expect_char("R6 low stop", 8'h81, 1'b0, 1'b1);
        chk(break_det === 1'b0, "R6 framing not break", int'(break_det), 0);
        read_both();
        chk(framing_err === 1'b0, "R10 status read clears framing", int'(framing_err), 0);
        line_ctrl = 8'h07; // two-stop setting, one and two stops sent
        send(8'h42, 0, 1'b1, 1);
        expect_char("R6 one stop with two-stop setting", 8'h42, 1'b0, 1'b0);
        read_both();
        send(8'h24, 0, 1'b1, 2);
        expect_char("R6 two stops", 8'h24, 1'b0, 1'b0);
        read_both();
    endtask

    task automatic t_break();
        line_ctrl = 8'h03;
        rx_in = 1'b0; wclk(12 * bitlen());
        rx_in = 1'b1; wclk(2 * bitlen());
        chk(break_det === 1'b1, "R7 break flagged", int'(break_det), 1);
        chk(framing_err === 1'b0, "R7 break not framing", int'(framing_err), 0);
        chk(data_ready === 1'b1 && rx_data === 8'h00, "R7 break char",
            int'({data_ready, rx_data}), 16'h100);
        read_both();
        chk(break_det === 1'b0, "R10 status read clears break", int'(break_det), 0);
        send(8'h5A, 0, 1'b1, 1);
        expect_char("R7 recover after break", 8'h5A, 1'b0, 1'b0);
        read_both();
    endtask

    task automatic t_false_start();
        line_ctrl = 8'h03;
        rx_in = 1'b0; wclk(5 * int'(divisor));
        rx_in = 1'b1; wclk(20 * bitlen());
        chk(data_ready === 1'b0, "R2 false start ignored", int'(data_ready), 0);
        chk(framing_err === 1'b0 && break_det === 1'b0, "R2 false start no flags",
            int'({framing_err, break_det}), 0);
        send(8'hC3, 0, 1'b1, 1);
        expect_char("R2 resync after false start", 8'hC3, 1'b0, 1'b0);
        read_both();
    endtask

    task automatic t_overrun();
        line_ctrl = 8'h03;
        send(8'h11, 0, 1'b1, 1);
        send(8'h22, 0, 1'b1, 1);
        chk(overrun_err === 1'b1, "R9 overrun flagged", int'(overrun_err), 1);
        chk(rx_data === 8'h22, "R9 newest kept", int'(rx_data), 8'h22);
        chk(data_ready === 1'b1, "R9 still ready", int'(data_ready), 1);
        @(posedge clk); #1; rd_status = 1'b1;
        @(posedge clk); #1; rd_status = 1'b0;
        chk(overrun_err === 1'b0, "R10 status read clears overrun", int'(overrun_err), 0);
        chk(data_ready === 1'b1, "R10 status read keeps ready", int'(data_ready), 1);
        read_both();
    endtask

    task automatic t_divisors();
        line_ctrl = 8'h03;
        divisor = 16'd1; wclk(4);
        send(8'h96, 0, 1'b1, 1);
        expect_char("R1 divisor 1", 8'h96, 1'b0, 1'b0);
        read_both();
        divisor = 16'd0; wclk(4);
        send(8'h69, 0, 1'b1, 1);
        expect_char("R1 divisor 0 as 1", 8'h69, 1'b0, 1'b0);
        read_both();
        divisor = 16'd7; wclk(40);
        send(8'hE7, 0, 1'b1, 1);
        expect_char("R1 divisor 7", 8'hE7, 1'b0, 1'b0);
        read_both();
    endtask

    initial begin
        wclk(5);
        rst_n = 1'b1;
        wclk(5);
        t_reset();
        t_basic();
        t_wordlen();
        t_parity();
        t_sticky();
        t_framing();
        t_break();
        t_false_start();
        t_overrun();
        t_divisors();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule